// File: doc/BRIEF.md
# Asynchronous Serial Byte Transmitter with Selectable Parity

This block turns one parallel byte at a time into an asynchronous serial frame on a single output line that rests high. A host offers a byte with a valid/ready handshake, together with a 3-bit parity selector. The block sends a low start bit, then the eight data bits least significant first, then an optional parity bit, then a high stop bit. A periodic one-cycle `baud_tick` enable, produced by an external clock divider, sets the bit period: every bit on the line lasts exactly one tick interval.

The parity selector picks one of five behaviours: odd, even, forced one (mark), forced zero (space), or none. With none, the parity slot is dropped and the stop bit follows the last data bit. The byte and the selector are captured when the byte is accepted, so the host may change both while a frame is in flight. A one-cycle `done_pulse` marks the end of each frame and can drive an interrupt request.

The control is a six-state machine. IDLE (line high, ready) goes to ARM when a byte is accepted. ARM holds the line high and waits for the next tick, so the start bit begins on a tick edge; on that tick it goes to START (line low). START goes to DATA on the next tick. DATA drives the current shift-register bit; each tick shifts, and the tick that ends the eighth bit goes to PARITY when a parity slot was selected, otherwise to STOP. PARITY goes to STOP on a tick. STOP drives the line high and goes back to IDLE on a tick, raising `done_pulse` for the next cycle. A synchronous reset returns the machine to IDLE from any state.

Top module: `serial_byte_sender`

## Requirements
- R1: While idle, including the cycle after reset, `line_out` is 1, `in_ready` is 1, `busy` is 0 and `done_pulse` is 0.
- R2: `rst` is synchronous and active high. After a clock edge with `rst` high, even in the middle of a frame, the line is 1, `in_ready` is 1 and `busy` is 0.
- R3: A byte is accepted on a clock edge where `in_valid` and `in_ready` are both 1. From the next cycle until the frame ends, `busy` is 1 and `in_ready` is 0. A request made while `in_ready` is 0 is ignored and starts no frame.
- R4: After acceptance the line stays high until the next `baud_tick`. The start bit (0) begins on the edge where that tick is sampled and no more than one tick interval after acceptance. Every bit lasts exactly one tick interval, and the line changes only on edges where `baud_tick` is 1.
- R5: The data bits follow the start bit least significant bit first. For example, 0x41 is sent as 1,0,0,0,0,0,1,0.
- R6: Selector 3'b001 (odd) sends a parity bit that makes data plus parity hold an odd number of ones. Selector 3'b010 (even) makes that count even. For 0x41, odd gives 1 and even gives 0.
- R7: Selector 3'b011 (mark) always sends 1 in the parity slot, and selector 3'b100 (space) always sends 0, whatever the data.
- R8: Selector 3'b000, and the unused codes 3'b101 to 3'b111, send no parity slot, so the stop bit follows the eighth data bit directly.
- R9: The data byte and the selector are captured at acceptance. Changing `in_data` or `mode_sel` during the frame has no effect on the frame.
- R10: The stop bit (1) lasts one tick interval. In the cycle after the tick that ends it, `done_pulse` is 1 for exactly one cycle while `in_ready` is already 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | 8 | Byte to send |
| in_valid | input | 1 | Host offers `in_data` |
| in_ready | output | 1 | Block can accept a byte (idle) |
| mode_sel | input | 3 | Parity selector: 000 none, 001 odd, 010 even, 011 mark, 100 space, others none |
| baud_tick | input | 1 | One-cycle enable per bit period |
| line_out | output | 1 | Serial line, high when idle |
| busy | output | 1 | A frame is in progress |
| done_pulse | output | 1 | One-cycle end-of-frame event |

## Verification
The embedded assertions check on every cycle that the line is high whenever the block is idle, that acceptance turns `busy` on and `in_ready` off, that a start bit follows the ARM tick, that the line never moves between ticks, and that `done_pulse` lasts one cycle and coincides with ready. What the line carries can only be shown by the bench's scenarios: the bit order, the parity value under each selector, the missing slot under none and unused codes, the capture of byte and selector at acceptance, recovery from a reset in mid-frame, and an ignored request while busy. The bench checks each bit over every cycle of its interval against frames built by its own functions.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    typedef enum logic [2:0] {
        PM_NONE  = 3'b000,
        PM_ODD   = 3'b001,
        PM_EVEN  = 3'b010,
        PM_MARK  = 3'b011,
        PM_SPACE = 3'b100
    } par_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_e;

endpackage

// File: rtl/sbs_parity_gen.sv
module sbs_parity_gen
    import sbs_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [2:0]        mode_i,
    output logic              par_bit_o,
    output logic              par_en_o
);

    logic ones_odd;

    assign ones_odd = ^data_i;

    always_comb begin
        par_bit_o = 1'b0;
        par_en_o  = 1'b1;
        case (mode_i)
            PM_ODD:   par_bit_o = ~ones_odd;
            PM_EVEN:  par_bit_o = ones_odd;
            PM_MARK:  par_bit_o = 1'b1;
            PM_SPACE: par_bit_o = 1'b0;
            default:  par_en_o  = 1'b0;
        endcase
    end

endmodule

// File: rtl/sbs_shift_reg.sv
module sbs_shift_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [DATA_W-1:0] load_data_i,
    input  logic              shift_i,
    output logic              ser_bit_o,
    output logic              last_bit_o
);

    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);

    logic [DATA_W-1:0] sreg_q;
    logic [CNT_W-1:0]  idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg_q <= '0;
            idx_q  <= '0;
        end else if (load_i) begin
            sreg_q <= load_data_i;
            idx_q  <= '0;
        end else if (shift_i) begin
            sreg_q <= sreg_q >> 1;
            idx_q  <= idx_q + 1'b1;
        end
    end

    assign ser_bit_o  = sreg_q[0];
    assign last_bit_o = (idx_q == LAST_IDX);

endmodule

// File: rtl/serial_byte_sender.sv
module serial_byte_sender
    import sbs_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int MODE_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [MODE_W-1:0] mode_sel,
    input  logic              baud_tick,
    output logic              line_out,
    output logic              busy,
    output logic              done_pulse
);

    tx_state_e state_q, state_d;
    logic      accept;
    logic      par_bit_now, par_en_now;
    logic      par_bit_q, par_en_q;
    logic      ser_bit, last_bit;
    logic      shift_en;
    logic      done_q;

    assign accept   = in_valid && (state_q == ST_IDLE);
    assign shift_en = (state_q == ST_DATA) && baud_tick;

    sbs_parity_gen #(.DATA_W(DATA_W)) u_par (
        .data_i    (in_data),
        .mode_i    (3'(mode_sel)),
        .par_bit_o (par_bit_now),
        .par_en_o  (par_en_now)
    );

    sbs_shift_reg #(.DATA_W(DATA_W)) u_shift (
        .clk         (clk),
        .rst         (rst),
        .load_i      (accept),
        .load_data_i (in_data),
        .shift_i     (shift_en),
        .ser_bit_o   (ser_bit),
        .last_bit_o  (last_bit)
    );

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept)    state_d = ST_ARM;
            ST_ARM:    if (baud_tick) state_d = ST_START;
            ST_START:  if (baud_tick) state_d = ST_DATA;
            ST_DATA:   if (baud_tick && last_bit)
                           state_d = par_en_q ? ST_PARITY : ST_STOP;
            ST_PARITY: if (baud_tick) state_d = ST_STOP;
            ST_STOP:   if (baud_tick) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register, captured frame settings, end-of-frame event
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            par_bit_q <= 1'b0;
            par_en_q  <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == ST_STOP) && baud_tick;
            if (accept) begin
                par_bit_q <= par_bit_now;
                par_en_q  <= par_en_now;
            end
        end
    end

    // output decode
    always_comb begin
        line_out = 1'b1;
        unique case (state_q)
            ST_IDLE, ST_ARM, ST_STOP: line_out = 1'b1;
            ST_START:                 line_out = 1'b0;
            ST_DATA:                  line_out = ser_bit;
            ST_PARITY:                line_out = par_bit_q;
            default:                  line_out = 1'b1;
        endcase
        in_ready   = (state_q == ST_IDLE);
        busy       = (state_q != ST_IDLE);
        done_pulse = done_q;
    end

    p_idle_line_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> line_out);

    p_accept_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (busy && !in_ready));

    p_start_after_arm_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ARM && baud_tick) |=> !line_out);

    p_no_move_between_ticks_r4: assert property (@(posedge clk) disable iff (rst)
        (busy && !baud_tick) |=> $stable(line_out));

    p_done_single_r10: assert property (@(posedge clk) disable iff (rst)
        done_pulse |=> !done_pulse);

    p_done_ready_r10: assert property (@(posedge clk) disable iff (rst)
        done_pulse |-> (in_ready && line_out));

endmodule

// File: tb/serial_byte_sender_tb.sv
`timescale 1ns/1ps
module serial_byte_sender_tb;

    localparam int DIV = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] in_data = '0;
    logic       in_valid = 1'b0;
    logic [2:0] mode_sel = '0;
    logic       baud_tick = 1'b0;
    logic       in_ready, line_out, busy, done_pulse;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    serial_byte_sender u_dut (
        .clk        (clk),
        .rst        (rst),
        .in_data    (in_data),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .mode_sel   (mode_sel),
        .baud_tick  (baud_tick),
        .line_out   (line_out),
        .busy       (busy),
        .done_pulse (done_pulse)
    );

    // free-running bit-period divider
    initial begin
        int c = 0;
        forever begin
            @(negedge clk);
            c = (c + 1) % DIV;
            baud_tick = (c == DIV - 1);
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit has_par(input logic [2:0] m);
        return (m >= 3'd1 && m <= 3'd4);
    endfunction

    function automatic logic par_val(input logic [7:0] d, input logic [2:0] m);
        case (m)
            3'd1:    return ~(^d);
            3'd2:    return ^d;
            3'd3:    return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic send_frame(input logic [7:0] d, input logic [2:0] m, input bit inject);
        logic  exp_bits [0:10];
        int    nb;
        int    waitc;
        bit    bad;
        logic  got;
        string tag;
        exp_bits[0] = 1'b0;
        for (int i = 0; i < 8; i++) exp_bits[i+1] = d[i];
        nb = 9;
        if (has_par(m)) begin
            exp_bits[nb] = par_val(d, m);
            nb++;
        end
        exp_bits[nb] = 1'b1;
        nb++;

        @(negedge clk);
        check(in_ready == 1'b1, "R3 ready before accept", int'(in_ready), 1);
        in_data  = d;
        mode_sel = m;
        in_valid = 1'b1;
        @(negedge clk);
        // R9: disturb inputs after acceptance
        in_valid = inject;
        in_data  = ~d;
        mode_sel = 3'($urandom_range(0, 7));
        check(busy && !in_ready, "R3 busy after accept", int'({busy, in_ready}), 2);

        waitc = 0;
        while (line_out == 1'b1 && waitc < DIV + 2) begin
            @(negedge clk);
            waitc++;
        end
        check(line_out == 1'b0 && waitc <= DIV, "R4 start within one tick interval", waitc, DIV);
        in_valid = 1'b0;

        for (int k = 0; k < nb; k++) begin
            bad = 1'b0;
            got = exp_bits[k];
            for (int c = 0; c < DIV; c++) begin
                if (line_out !== exp_bits[k]) begin
                    bad = 1'b1;
                    got = line_out;
                end
                @(negedge clk);
            end
            if (k == 0)                  tag = "R4 start bit";
            else if (k <= 8)             tag = "R5 R9 data bit";
            else if (k == nb - 1)        tag = has_par(m) ? "R10 stop bit" : "R8 stop follows data";
            else if (m == 3'd1 || m == 3'd2) tag = "R6 parity bit";
            else                         tag = "R7 parity bit";
            check(!bad, tag, int'(got), int'(exp_bits[k]));
        end

        check(done_pulse && in_ready && line_out, "R10 done with ready",
              int'({done_pulse, in_ready, line_out}), 7);
        @(negedge clk);
        check(!done_pulse, "R10 done one cycle", int'(done_pulse), 0);
    endtask

    initial begin : watchdog
        #500000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        bit idle_bad;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check(line_out && in_ready && !busy && !done_pulse, "R1 reset state",
              int'({line_out, in_ready, busy, done_pulse}), 4'b1100);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check(line_out && in_ready && !busy, "R1 idle state",
              int'({line_out, in_ready, busy}), 3'b110);

        // directed frames
        send_frame(8'h41, 3'd1, 1'b0);   // R6 odd -> 1
        send_frame(8'h41, 3'd2, 1'b0);   // R6 even -> 0
        send_frame(8'h41, 3'd3, 1'b0);   // R7 mark
        send_frame(8'h41, 3'd4, 1'b0);   // R7 space
        send_frame(8'h41, 3'd0, 1'b0);   // R8 none
        send_frame(8'h00, 3'd1, 1'b0);
        send_frame(8'hFF, 3'd2, 1'b0);
        send_frame(8'hFF, 3'd4, 1'b0);
        send_frame(8'h00, 3'd3, 1'b0);
        send_frame(8'h3C, 3'd6, 1'b0);   // R8 unused code
        send_frame(8'hC3, 3'd7, 1'b0);

        // R3: request while busy is ignored
        send_frame(8'hA5, 3'd2, 1'b1);
        idle_bad = 1'b0;
        repeat (3 * DIV) begin
            if (!line_out || busy) idle_bad = 1'b1;
            @(negedge clk);
        end
        check(!idle_bad, "R3 request while busy ignored", int'(idle_bad), 0);

        // R2: reset in mid-frame
        @(negedge clk);
        in_data  = 8'h00;
        mode_sel = 3'd4;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3 * DIV) @(negedge clk);
        check(busy, "R2 frame in progress before reset", int'(busy), 1);
        rst = 1'b1;
        @(negedge clk);
        check(line_out && in_ready && !busy, "R2 reset mid-frame",
              int'({line_out, in_ready, busy}), 3'b110);
        rst = 1'b0;
        send_frame(8'h5A, 3'd1, 1'b0);

        // random frames
        for (int n = 0; n < 30; n++) begin
            send_frame(8'($urandom_range(0, 255)), 3'($urandom_range(0, 7)), 1'b0);
            repeat ($urandom_range(0, 5)) @(negedge clk);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule